// File: doc/BRIEF.md
# UART Baud Tick Generator with Split Divisor Load

This block produces the timing strobes a UART needs from the bus clock. A 13-bit divisor D sets the rate: a one-cycle sample strobe appears once every D bus clocks, and every sixteenth sample strobe is also marked as a bit strobe. The line bit rate is therefore the bus clock divided by 16·D. Software loads D through two 8-bit writes on one shared data bus, one to an upper register and one to a lower register.

A write to the upper register only fills a staging buffer. The running divisor changes only when the lower register is written, and both halves take effect on that edge. The prescale counters restart at that moment, so the first strobe under the new divisor comes a full period later. A divisor of zero stops the counters. After reset the counters also stay still until the transmit enable or the receive enable is raised for the first time. The upper register also carries three control bits for the neighbouring UART logic: a break-interrupt enable, a receive-edge interrupt enable and a stop-bit count select. These are presented as plain outputs.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the upper register reads 0x00, the three control outputs are 0, both strobes are low, and the running divisor is 4 (upper 0x00, lower 0x04).
- R2: No strobe is produced after reset until tx_en or rx_en has been sampled high at least once. From that edge on the generator keeps running when both enables drop again.
- R3: With a running divisor D of 1 or more, sample_tick is a one-cycle pulse that repeats every D cycles.
- R4: bit_tick pulses together with every sixteenth sample_tick, counted from the last counter restart, and at no other time.
- R5: A strobe on hi_wr stores wdata in the staging buffer. hi_rdata returns this buffer one cycle later, and the strobe timing does not change.
- R6: A strobe on lo_wr loads the running divisor as {staging[4:0], wdata} and restarts both counters. The first sample_tick is high in the cycle that follows the (D-1)th clock edge after the capturing edge.
- R7: A lo_wr with no hi_wr since the previous lo_wr keeps the upper five divisor bits unchanged.
- R8: While the running divisor is 0, neither strobe is produced. A later non-zero load restarts the strobes as described in R6.
- R9: Staging bits 7, 6 and 5 drive brk_irq_en, edge_irq_en and two_stop respectively, from the cycle after hi_wr onward. A set stop-bit output means two stop bits.
- R10: The divisor limits behave as in R3: D=1 gives a sample strobe every cycle and a bit strobe every 16 cycles, and D=8191 gives one sample strobe every 8191 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_wr | input | 1 | Write strobe for the upper register (staging buffer) |
| lo_wr | input | 1 | Write strobe for the lower register; loads the divisor |
| wdata | input | 8 | Write data shared by both strobes |
| tx_en | input | 1 | Transmitter enable; its first high level starts the generator |
| rx_en | input | 1 | Receiver enable; its first high level starts the generator |
| hi_rdata | output | 8 | Contents of the staging buffer |
| sample_tick | output | 1 | 16x oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Once-per-bit strobe, one cycle wide |
| brk_irq_en | output | 1 | Break-detect interrupt enable (staging bit 7) |
| edge_irq_en | output | 1 | Receive active-edge interrupt enable (staging bit 6) |
| two_stop | output | 1 | Stop-bit select: 0 one stop bit, 1 two stop bits (staging bit 5) |

## Verification
Strobes are due D-1 clock edges after the edge that captures a lower-register write or the first enable, and then every D edges. Bit strobes are due every 16·D edges from the same origin. Readback and the control outputs are due one edge after hi_wr. The bench keeps a cycle index that advances on every rising edge and drives inputs mid-cycle. For each observation window it computes the exact cycle indices of the expected strobes from the divisor and origin it tracks itself, pushes them into queues, and lets a falling-edge monitor match each observed strobe against the head of its queue. A window must end with both queues empty.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BAUD_DATA_W = 8;
  localparam int BAUD_DIV_W  = 13;
  localparam int BAUD_OVS    = 16;
  localparam logic [7:0] BAUD_HI_RST = 8'h00;
  localparam logic [7:0] BAUD_LO_RST = 8'h04;

  // Bit positions of the control fields in the upper register
  localparam int BRK_IE_BIT  = 7;
  localparam int EDGE_IE_BIT = 6;
  localparam int STOP_BIT    = 5;

  // Advance a modulo counter, wrapping at a given limit
  function automatic int unsigned wrap_inc(input int unsigned val, input int unsigned limit);
    return (val + 1 >= limit) ? 0 : val + 1;
  endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 13,
  parameter logic [DATA_W-1:0] HI_RST = '0,
  parameter logic [DATA_W-1:0] LO_RST = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hi_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              load_ev
);
  localparam int HI_W = DIV_W - DATA_W;

  logic pend_q;

  // Merge the low byte with either the staged upper bits or the current ones
  function automatic logic [DIV_W-1:0] merge_div(
    input logic              use_stage,
    input logic [HI_W-1:0]   stage_bits,
    input logic [HI_W-1:0]   cur_bits,
    input logic [DATA_W-1:0] low_bits
  );
    return {(use_stage ? stage_bits : cur_bits), low_bits};
  endfunction

  assign load_ev = lo_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= HI_RST;
      pend_q <= 1'b0;
      div_q  <= {HI_RST[HI_W-1:0], LO_RST};
    end else begin
      if (lo_wr) begin
        div_q <= merge_div(pend_q, hi_q[HI_W-1:0], div_q[DIV_W-1:DATA_W], wdata);
      end
      if (hi_wr) begin
        hi_q   <= wdata;
        pend_q <= 1'b1;
      end else if (lo_wr) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr) |=> $stable(div_q)); // R5
  AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !pend_q) |=> (div_q[DIV_W-1:DATA_W] == $past(div_q[DIV_W-1:DATA_W]))); // R7
  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (div_q[DATA_W-1:0] == $past(wdata))); // R6
endmodule

// File: rtl/baud_arm.sv
module baud_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_en,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)               armed <= 1'b0;
    else if (tx_en || rx_en)  armed <= 1'b1;
  end

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed); // R2
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [DIV_W-1:0] div_q,
  output logic             sample_tick,
  output logic             bit_tick
);
  import baud_pkg::*;
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [DIV_W-1:0] cnt_q;
  logic [SUB_W-1:0] sub_q;
  logic             term_ev;
  logic             sub_wrap_ev;

  // Last count of a period of length d
  function automatic logic at_terminal(input logic [DIV_W-1:0] c, input logic [DIV_W-1:0] d);
    return c == (d - DIV_W'(1));
  endfunction

  assign term_ev     = run && at_terminal(cnt_q, div_q);
  assign sub_wrap_ev = (int'(sub_q) == OVS - 1);
  assign sample_tick = term_ev;
  assign bit_tick    = term_ev && sub_wrap_ev;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || reload) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (term_ev) begin
      cnt_q <= '0;
      sub_q <= SUB_W'(wrap_inc(int'(sub_q), OVS));
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && div_q > DIV_W'(1) && !reload) |=> !sample_tick); // R3
  AST_BIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R4
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (!sample_tick || div_q == DIV_W'(1))); // R6
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DATA_W = baud_pkg::BAUD_DATA_W,
  parameter int DIV_W  = baud_pkg::BAUD_DIV_W,
  parameter int OVS    = baud_pkg::BAUD_OVS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_en,
  input  logic              rx_en,
  output logic [DATA_W-1:0] hi_rdata,
  output logic              sample_tick,
  output logic              bit_tick,
  output logic              brk_irq_en,
  output logic              edge_irq_en,
  output logic              two_stop
);
  import baud_pkg::*;

  logic [DATA_W-1:0] hi_q;
  logic [DIV_W-1:0]  div_q;
  logic              load_ev;
  logic              armed;
  logic              run;

  baud_regs #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .HI_RST (DATA_W'(BAUD_HI_RST)),
    .LO_RST (DATA_W'(BAUD_LO_RST))
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_wr   (hi_wr),
    .lo_wr   (lo_wr),
    .wdata   (wdata),
    .hi_q    (hi_q),
    .div_q   (div_q),
    .load_ev (load_ev)
  );

  baud_arm u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .rx_en (rx_en),
    .armed (armed)
  );

  assign run = armed && (div_q != '0);

  baud_prescale #(
    .DIV_W (DIV_W),
    .OVS   (OVS)
  ) u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .reload      (load_ev),
    .div_q       (div_q),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  assign hi_rdata    = hi_q;
  assign brk_irq_en  = hi_q[BRK_IE_BIT];
  assign edge_irq_en = hi_q[EDGE_IE_BIT];
  assign two_stop    = hi_q[STOP_BIT];

  AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !tx_en && !rx_en) |=> !sample_tick); // R2
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> (!sample_tick && !bit_tick)); // R8
  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (sample_tick && armed)); // R4
endmodule

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi_wr = 1'b0, lo_wr = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] hi_rdata;
  logic       sample_tick, bit_tick, brk_irq_en, edge_irq_en, two_stop;

  uart_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr), .wdata(wdata),
    .tx_en(tx_en), .rx_en(rx_en), .hi_rdata(hi_rdata), .sample_tick(sample_tick),
    .bit_tick(bit_tick), .brk_irq_en(brk_irq_en), .edge_irq_en(edge_irq_en),
    .two_stop(two_stop)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the generator
  bit   armed_m = 0;
  bit   pend_m  = 0;
  logic [7:0]  hi_m = '0;
  logic [12:0] div_m = 13'd4;
  int   base_m = 0;

  // Scoreboard queues of expected strobe cycles
  int sq[$];
  int bq[$];
  bit win_on = 0;
  int win_s = 0;
  string win_tag = "";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected strobes as the design produces them
  always @(negedge clk) begin
    if (win_on && cyc >= win_s) begin
      bit es, eb;
      es = (sq.size() > 0) && (sq[0] == cyc);
      eb = (bq.size() > 0) && (bq[0] == cyc);
      if (es) void'(sq.pop_front());
      if (eb) void'(bq.pop_front());
      if (es || sample_tick) chk(sample_tick == es, {win_tag, " sample_tick"}, int'(sample_tick), int'(es));
      if (eb || bit_tick)    chk(bit_tick == eb, {win_tag, " bit_tick"}, int'(bit_tick), int'(eb));
    end
  end

  task automatic clear_strobes();
    hi_wr = 0; lo_wr = 0; tx_en = 0; rx_en = 0;
  endtask

  task automatic wr_hi(input logic [7:0] v);
    @(posedge clk); #5;
    hi_wr = 1; wdata = v; hi_m = v; pend_m = 1;
    @(posedge clk); #5;
    clear_strobes();
  endtask

  task automatic wr_lo(input logic [7:0] v);
    @(posedge clk); #5;
    lo_wr = 1; wdata = v;
    div_m = pend_m ? {hi_m[4:0], v} : {div_m[12:8], v};
    pend_m = 0; base_m = cyc;
    @(posedge clk); #5;
    clear_strobes();
  endtask

  task automatic enable(input bit use_rx);
    @(posedge clk); #5;
    if (use_rx) rx_en = 1; else tx_en = 1;
    if (!armed_m) begin armed_m = 1; base_m = cyc; end
    @(posedge clk); #5;
    clear_strobes();
  endtask

  // Driver: pushes the strobes the model predicts in [s, s+len], then waits
  task automatic run_window(input int len, input string tag);
    int s;
    s = cyc;
    for (int t = s; t <= s + len; t++) begin
      if (armed_m && div_m != 0 && t > base_m) begin
        if ((t - base_m) % int'(div_m) == 0) sq.push_back(t);
        if ((t - base_m) % (16 * int'(div_m)) == 0) bq.push_back(t);
      end
    end
    win_tag = tag; win_s = s; win_on = 1;
    repeat (len) @(posedge clk);
    #11;
    win_on = 0;
    chk(sq.size() == 0, {tag, " missing sample strobes"}, sq.size(), 0);
    chk(bq.size() == 0, {tag, " missing bit strobes"}, bq.size(), 0);
    sq.delete(); bq.delete();
  endtask

  task automatic do_reset();
    @(posedge clk); #5;
    rst_n = 0; clear_strobes();
    repeat (3) @(posedge clk);
    #5; rst_n = 1;
    armed_m = 0; pend_m = 0; hi_m = '0; div_m = 13'd4;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(sample_tick == 0, "R1 sample_tick after reset", int'(sample_tick), 0);
    chk(bit_tick == 0, "R1 bit_tick after reset", int'(bit_tick), 0);
    chk(hi_rdata == 8'h00, "R1 hi_rdata after reset", int'(hi_rdata), 0);
    chk({brk_irq_en, edge_irq_en, two_stop} == 3'b000, "R1 control outputs", int'({brk_irq_en, edge_irq_en, two_stop}), 0);

    run_window(100, "R2 idle before enable");
    enable(0);                          // one-cycle tx_en pulse, reset divisor 4
    run_window(140, "R1 R2 R3 R4 default divisor");

    wr_hi(8'hE1);
    @(negedge clk);
    chk(hi_rdata == 8'hE1, "R5 staging readback", int'(hi_rdata), 8'hE1);
    chk(brk_irq_en == 1, "R9 break irq enable", int'(brk_irq_en), 1);
    chk(edge_irq_en == 1, "R9 edge irq enable", int'(edge_irq_en), 1);
    chk(two_stop == 1, "R9 two stop bits", int'(two_stop), 1);
    run_window(40, "R5 divisor unchanged after upper write");

    wr_lo(8'h03);                       // D = 0x103 = 259
    run_window(4200, "R6 R4 load 259");
    wr_lo(8'h05);                       // D = 0x105 = 261
    run_window(600, "R7 upper bits kept");

    wr_hi(8'h00);
    @(negedge clk);
    chk(two_stop == 0, "R9 one stop bit", int'(two_stop), 0);
    chk(brk_irq_en == 0, "R9 break irq disable", int'(brk_irq_en), 0);
    wr_lo(8'h01);                       // D = 1
    run_window(40, "R10 divisor 1");

    wr_hi(8'h1F);
    wr_lo(8'hFF);                       // D = 8191
    run_window(16400, "R10 divisor 8191");

    wr_hi(8'h00);
    wr_lo(8'h00);                       // D = 0
    run_window(300, "R8 zero divisor");
    wr_lo(8'h02);                       // D = 2
    run_window(80, "R8 restart after zero");

    do_reset();
    @(negedge clk);
    chk(hi_rdata == 8'h00, "R1 hi_rdata after second reset", int'(hi_rdata), 0);
    run_window(60, "R2 idle after second reset");
    enable(1);                          // rx_en path
    run_window(140, "R2 R3 receive enable starts generator");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule